// File: doc/BRIEF.md
# Bus Slave Address and Strobe Decoder for a 32-Channel Digitizer

This block sits between an asynchronous 24-bit-address, 16-bit-data backplane bus and the channel logic of a 32-channel waveform digitizer board. Sampled in the board clock domain, it watches the address strobe and data strobe. When both are active it captures the address, modifier code, direction and write word. It then checks that the top address byte equals the board's 8-bit switch setting and that the modifier code suits the access. The access is classed as one of five kinds: control write, threshold write, single-channel buffer read, merged-buffer block read or block-beat count read.

A recognised access produces a one-cycle strobe toward the channel logic, and read data where the access is a read. The data acknowledge is raised in the same cycle. An access that is not recognised is never acknowledged and changes nothing. In a block transfer the master holds the address strobe and toggles the data strobe, and each new data strobe is served as a further beat from the merged-buffer port without capturing the address again.

The control flow is a five-state machine. IDLE captures the access when both strobes are seen. DECODE classes the latched access and moves to ACK on a hit or REJECT on a miss. ACK holds the acknowledge until the data strobe falls, then returns to IDLE, or enters BEAT_WAIT when the access was a merged read and the address strobe is still held. REJECT waits for the data strobe to fall and returns to IDLE. BEAT_WAIT returns to IDLE when the address strobe falls, or goes back to DECODE when the data strobe rises again.

Top module: `vme_slave_decode`

## Requirements
- R1: After reset `dtack_o` and every strobe output are low, `rdata_o` is 0 and `samp_count_o` is 1020.
- R2: An access is answered only when `addr_i[23:16]` equals `mod_id_i`. Any other access never raises `dtack_o`, pulses no strobe and leaves `samp_count_o`, `rdata_o` and the beat count unchanged.
- R3: Modifier 0x3D is the only code accepted for control writes, threshold writes and single-channel reads. Modifiers 0x3B and 0x3F are the only codes accepted for the merged read and the beat-count read, and both of those must be reads. Every other combination is treated as in R2.
- R4: Call the first clock edge that samples `as_i` and `ds_i` both high edge one. On an accepted access `dtack_o` rises at edge two, stays high while `ds_i` stays high, and falls at the first edge that samples `ds_i` low.
- R5: A write with modifier 0x3D to offset 0x0000 pulses `fifo_clr_o` if data bit 9 is set, `thr_clr_o` if bit 10 is set and `samp_load_o` if bit 11 is set. Any mix of these bits may be set together. Each pulse lasts one cycle and coincides with the first cycle of `dtack_o`.
- R6: On a control write with bit 11 set, `samp_count_o` takes data bits 9:0. `samp_count_o` changes at no other time.
- R7: A write with modifier 0x3D to offset j·0x100, where j is 1 to 32, pulses bit j−1 of `thr_load_o` for one cycle and puts the written word on `thr_data_o`. An offset with a nonzero low byte, or with j above 32, is not answered.
- R8: A read with modifier 0x3D at offset j·0x100, where j is 1 to 32, pulses bit j−1 of `ch_rd_o` for one cycle. `rdata_o` then holds the word at bits (j−1)·16+15 down to (j−1)·16 of `ch_data_i`, as sampled at the edge that raises `dtack_o`.
- R9: A read at offset 0x0100 with modifier 0x3B or 0x3F pulses `merged_rd_o` for one cycle. `rdata_o` then holds `merged_data_i` as sampled at the edge that raises `dtack_o`.
- R10: While `as_i` stays high after a merged read, each further rise of `ds_i` is served as another merged beat with the timing of R4, whatever `addr_i` and `am_i` then show.
- R11: A read at offset 0x0101 with modifier 0x3B or 0x3F returns in `rdata_o` the number of merged beats served since reset or since the last control write with bit 9 set.
- R12: At most one bit among `ch_rd_o`, `thr_load_o` and `merged_rd_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst_n | input | 1 | Active-low synchronous reset |
| as_i | input | 1 | Address strobe, active high |
| ds_i | input | 1 | Data strobe, active high |
| write_i | input | 1 | 1 = write access, 0 = read |
| am_i | input | 6 | Address modifier code |
| addr_i | input | 24 | Bus address |
| wdata_i | input | 16 | Write data |
| mod_id_i | input | 8 | Board select switch value |
| ch_data_i | input | 512 | Head word of each channel buffer, channel k at bits k·16+15 down to k·16 |
| merged_data_i | input | 16 | Head word of the merged buffer |
| rdata_o | output | 16 | Read data toward the bus |
| dtack_o | output | 1 | Data acknowledge, active high |
| fifo_clr_o | output | 1 | Buffer reset pulse |
| thr_clr_o | output | 1 | Threshold reset pulse |
| samp_load_o | output | 1 | Sample-count load pulse |
| samp_count_o | output | 10 | Current sample count |
| thr_load_o | output | 32 | Per-channel threshold load pulses |
| thr_data_o | output | 16 | Threshold write word |
| ch_rd_o | output | 32 | Per-channel buffer read pulses |
| merged_rd_o | output | 1 | Merged buffer read pulse |

## Verification
Random accesses are drawn from a fixed seed and mix a matching or stray board select, single-cycle, block or arbitrary modifiers, both directions, and offsets clustered on the control word, the merged and count words, channel slots beyond 32 and nonzero low bytes. These patterns separate decoding by address from decoding by modifier, and an answered access from one that is ignored but still applies a side effect. Directed cases cover the reset state, a three-beat block burst whose address bus is scrambled after the first beat, which shows that beats reuse the captured access, the beat count before and after a buffer reset, and the first and last channel slots.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECODE,
        S_ACK,
        S_REJECT,
        S_BEAT_WAIT
    } vsd_state_t;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CTRL,
        ACC_THR,
        ACC_CHRD,
        ACC_MERGE,
        ACC_BCNT
    } vsd_acc_t;

    localparam logic [5:0] AM_SINGLE = 6'h3D;
    localparam logic [5:0] AM_BLK_A  = 6'h3B;
    localparam logic [5:0] AM_BLK_B  = 6'h3F;

    localparam int CTRL_FIFO_BIT = 9;
    localparam int CTRL_THR_BIT  = 10;
    localparam int CTRL_SAMP_BIT = 11;

    localparam logic [15:0] OFF_CTRL  = 16'h0000;
    localparam logic [15:0] OFF_MERGE = 16'h0100;
    localparam logic [15:0] OFF_BCNT  = 16'h0101;

    localparam int STRIDE_LSB = 8;

endpackage

// File: rtl/vsd_addr_match.sv
module vsd_addr_match
    import vsd_pkg::*;
#(
    parameter int NCH = 32,
    parameter int AW  = 24,
    parameter int IDW = 8,
    parameter int AMW = 6,
    parameter int CIW = 5
) (
    input  logic [AW-1:0]  addr_i,
    input  logic [AMW-1:0] am_i,
    input  logic           write_i,
    input  logic [IDW-1:0] mod_id_i,
    output vsd_acc_t       kind_o,
    output logic [CIW-1:0] ch_idx_o
);
    localparam int OFFW = AW - IDW;
    localparam int CHW  = OFFW - STRIDE_LSB;
    localparam logic [CHW-1:0] NCH_V = CHW'(NCH);

    logic            base_ok;
    logic            is_single;
    logic            is_block;
    logic            chn_ok;
    logic [OFFW-1:0] off;
    logic [CHW-1:0]  chn;

    always_comb begin
        base_ok   = (addr_i[AW-1:OFFW] == mod_id_i);
        off       = addr_i[OFFW-1:0];
        chn       = off[OFFW-1:STRIDE_LSB];
        is_single = (am_i == AM_SINGLE);
        is_block  = (am_i == AM_BLK_A) || (am_i == AM_BLK_B);
        chn_ok    = (off[STRIDE_LSB-1:0] == '0) && (chn != '0) && (chn <= NCH_V);
        kind_o    = ACC_NONE;
        if (base_ok) begin
            if (is_single && write_i && off == OFF_CTRL)
                kind_o = ACC_CTRL;
            else if (is_single && chn_ok)
                kind_o = write_i ? ACC_THR : ACC_CHRD;
            else if (is_block && !write_i && off == OFF_MERGE)
                kind_o = ACC_MERGE;
            else if (is_block && !write_i && off == OFF_BCNT)
                kind_o = ACC_BCNT;
        end
        ch_idx_o = CIW'(chn - CHW'(1));
    end

endmodule

// File: rtl/vsd_fsm.sv
module vsd_fsm
    import vsd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     as_i,
    input  logic     ds_i,
    input  vsd_acc_t kind_i,
    output logic     latch_o,
    output logic     fire_o,
    output logic     dtack_o
);
    vsd_state_t state;
    vsd_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:      if (as_i && ds_i) nxt = S_DECODE;
            S_DECODE:    nxt = (kind_i == ACC_NONE) ? S_REJECT : S_ACK;
            S_ACK:       if (!ds_i) nxt = (as_i && kind_i == ACC_MERGE) ? S_BEAT_WAIT : S_IDLE;
            S_REJECT:    if (!ds_i) nxt = S_IDLE;
            S_BEAT_WAIT: if (!as_i) nxt = S_IDLE;
                         else if (ds_i) nxt = S_DECODE;
            default:     nxt = S_IDLE;
        endcase
    end

    always_comb begin
        latch_o = (state == S_IDLE) && as_i && ds_i;
        fire_o  = (state == S_DECODE) && (kind_i != ACC_NONE);
        dtack_o = (state == S_ACK);
    end

    // R4
    dtack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dtack_o && !ds_i) |=> !dtack_o);

    // R4
    dtack_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtack_o) |-> $past(as_i && ds_i, 2));

endmodule

// File: rtl/vsd_datapath.sv
module vsd_datapath
    import vsd_pkg::*;
#(
    parameter int NCH      = 32,
    parameter int DW       = 16,
    parameter int SCW      = 10,
    parameter int SAMP_DEF = 1020,
    parameter int CIW      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  vsd_acc_t          kind_i,
    input  logic [CIW-1:0]    ch_idx_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [NCH*DW-1:0] ch_data_i,
    input  logic [DW-1:0]     merged_data_i,
    output logic [DW-1:0]     rdata_o,
    output logic              fifo_clr_o,
    output logic              thr_clr_o,
    output logic              samp_load_o,
    output logic [SCW-1:0]    samp_count_o,
    output logic [NCH-1:0]    thr_load_o,
    output logic [DW-1:0]     thr_data_o,
    output logic [NCH-1:0]    ch_rd_o,
    output logic              merged_rd_o
);
    logic [DW-1:0]  ch_words [NCH];
    logic [NCH-1:0] ch_hit;
    logic [DW-1:0]  beat_cnt;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign ch_words[g] = ch_data_i[g*DW +: DW];
        assign ch_hit[g]   = (ch_idx_i == CIW'(g));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o      <= '0;
            fifo_clr_o   <= 1'b0;
            thr_clr_o    <= 1'b0;
            samp_load_o  <= 1'b0;
            samp_count_o <= SCW'(SAMP_DEF);
            thr_load_o   <= '0;
            thr_data_o   <= '0;
            ch_rd_o      <= '0;
            merged_rd_o  <= 1'b0;
            beat_cnt     <= '0;
        end else begin
            fifo_clr_o  <= 1'b0;
            thr_clr_o   <= 1'b0;
            samp_load_o <= 1'b0;
            thr_load_o  <= '0;
            ch_rd_o     <= '0;
            merged_rd_o <= 1'b0;
            if (fire_i) begin
                unique case (kind_i)
                    ACC_CTRL: begin
                        fifo_clr_o  <= wdata_i[CTRL_FIFO_BIT];
                        thr_clr_o   <= wdata_i[CTRL_THR_BIT];
                        samp_load_o <= wdata_i[CTRL_SAMP_BIT];
                        if (wdata_i[CTRL_SAMP_BIT]) samp_count_o <= wdata_i[SCW-1:0];
                        if (wdata_i[CTRL_FIFO_BIT]) beat_cnt <= '0;
                    end
                    ACC_THR: begin
                        thr_load_o <= ch_hit;
                        thr_data_o <= wdata_i;
                    end
                    ACC_CHRD: begin
                        ch_rd_o <= ch_hit;
                        rdata_o <= ch_words[ch_idx_i];
                    end
                    ACC_MERGE: begin
                        merged_rd_o <= 1'b1;
                        rdata_o     <= merged_data_i;
                        beat_cnt    <= beat_cnt + 1'b1;
                    end
                    ACC_BCNT: rdata_o <= beat_cnt;
                    default: ;
                endcase
            end
        end
    end

    // R6
    samp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_count_o != $past(samp_count_o)) |-> samp_load_o);

endmodule

// File: rtl/vme_slave_decode.sv
module vme_slave_decode
    import vsd_pkg::*;
#(
    parameter int NCH      = 32,
    parameter int DW       = 16,
    parameter int AW       = 24,
    parameter int IDW      = 8,
    parameter int AMW      = 6,
    parameter int SCW      = 10,
    parameter int SAMP_DEF = 1020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_i,
    input  logic              ds_i,
    input  logic              write_i,
    input  logic [AMW-1:0]    am_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [IDW-1:0]    mod_id_i,
    input  logic [NCH*DW-1:0] ch_data_i,
    input  logic [DW-1:0]     merged_data_i,
    output logic [DW-1:0]     rdata_o,
    output logic              dtack_o,
    output logic              fifo_clr_o,
    output logic              thr_clr_o,
    output logic              samp_load_o,
    output logic [SCW-1:0]    samp_count_o,
    output logic [NCH-1:0]    thr_load_o,
    output logic [DW-1:0]     thr_data_o,
    output logic [NCH-1:0]    ch_rd_o,
    output logic              merged_rd_o
);
    localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [AW-1:0]  addr_q;
    logic [AMW-1:0] am_q;
    logic           write_q;
    logic [DW-1:0]  wdata_q;
    logic           latch;
    logic           fire;
    vsd_acc_t       kind;
    logic [CIW-1:0] ch_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            am_q    <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
        end else if (latch) begin
            addr_q  <= addr_i;
            am_q    <= am_i;
            write_q <= write_i;
            wdata_q <= wdata_i;
        end
    end

    vsd_addr_match #(.NCH(NCH), .AW(AW), .IDW(IDW), .AMW(AMW), .CIW(CIW)) u_match (
        .addr_i   (addr_q),
        .am_i     (am_q),
        .write_i  (write_q),
        .mod_id_i (mod_id_i),
        .kind_o   (kind),
        .ch_idx_o (ch_idx)
    );

    vsd_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .as_i    (as_i),
        .ds_i    (ds_i),
        .kind_i  (kind),
        .latch_o (latch),
        .fire_o  (fire),
        .dtack_o (dtack_o)
    );

    vsd_datapath #(.NCH(NCH), .DW(DW), .SCW(SCW), .SAMP_DEF(SAMP_DEF), .CIW(CIW)) u_dp (
        .clk           (clk),
        .rst_n         (rst_n),
        .fire_i        (fire),
        .kind_i        (kind),
        .ch_idx_i      (ch_idx),
        .wdata_i       (wdata_q),
        .ch_data_i     (ch_data_i),
        .merged_data_i (merged_data_i),
        .rdata_o       (rdata_o),
        .fifo_clr_o    (fifo_clr_o),
        .thr_clr_o     (thr_clr_o),
        .samp_load_o   (samp_load_o),
        .samp_count_o  (samp_count_o),
        .thr_load_o    (thr_load_o),
        .thr_data_o    (thr_data_o),
        .ch_rd_o       (ch_rd_o),
        .merged_rd_o   (merged_rd_o)
    );

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({merged_rd_o, ch_rd_o, thr_load_o}));

    // R5
    side_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_clr_o || thr_clr_o || samp_load_o || merged_rd_o || (|ch_rd_o) || (|thr_load_o))
        |-> (dtack_o && !$past(dtack_o)));

    // R5
    ctrl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_clr_o || thr_clr_o || samp_load_o) |=> !(fifo_clr_o || thr_clr_o || samp_load_o));

    // R2
    ack_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtack_o) |-> (addr_q[AW-1:AW-IDW] == mod_id_i));

endmodule

// File: tb/vme_slave_decode_bench.sv
module vme_slave_decode_bench;
    localparam int NCH = 32;
    localparam int DW  = 16;
    localparam logic [7:0] MOD_ID = 8'h05;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              as_i = 1'b0, ds_i = 1'b0, write_i = 1'b0;
    logic [5:0]        am_i = '0;
    logic [23:0]       addr_i = '0;
    logic [15:0]       wdata_i = '0;
    logic [7:0]        mod_id_i = MOD_ID;
    logic [NCH*DW-1:0] ch_data_i;
    logic [15:0]       merged_data_i = '0;
    logic [15:0]       rdata_o;
    logic              dtack_o, fifo_clr_o, thr_clr_o, samp_load_o, merged_rd_o;
    logic [9:0]        samp_count_o;
    logic [NCH-1:0]    thr_load_o, ch_rd_o;
    logic [15:0]       thr_data_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    vme_slave_decode u_vme_slave_decode (
        .clk(clk), .rst_n(rst_n), .as_i(as_i), .ds_i(ds_i), .write_i(write_i),
        .am_i(am_i), .addr_i(addr_i), .wdata_i(wdata_i), .mod_id_i(mod_id_i),
        .ch_data_i(ch_data_i), .merged_data_i(merged_data_i), .rdata_o(rdata_o),
        .dtack_o(dtack_o), .fifo_clr_o(fifo_clr_o), .thr_clr_o(thr_clr_o),
        .samp_load_o(samp_load_o), .samp_count_o(samp_count_o), .thr_load_o(thr_load_o),
        .thr_data_o(thr_data_o), .ch_rd_o(ch_rd_o), .merged_rd_o(merged_rd_o)
    );

    // model state
    logic [9:0]  m_samp = 10'd1020;
    logic [15:0] m_beats = '0;
    logic [15:0] m_rdata = '0;

    // captured per access
    logic        g_dt_early, g_dt, g_dt_hold, g_dt_rel, g_pulse2;
    logic        g_fclr, g_tclr, g_sload, g_mrd;
    logic [31:0] g_thr, g_chrd;
    logic [15:0] g_rdata, g_tdata;

    function automatic logic [15:0] chword(int k);
        return 16'(k * 16'h0111) ^ 16'h5A00;
    endfunction

    // 0 none, 1 ctrl, 2 thr, 3 chan read, 4 merged, 5 beat count
    function automatic int exp_kind(logic [23:0] a, logic [5:0] m, logic wr);
        logic [7:0] c;
        logic sc, bk;
        c  = a[15:8];
        sc = (m == 6'h3D);
        bk = (m == 6'h3B) || (m == 6'h3F);
        if (a[23:16] != MOD_ID) return 0;
        if (sc && wr && a[15:0] == 16'h0000) return 1;
        if (sc && a[7:0] == 8'h00 && c >= 8'd1 && c <= 8'd32) return wr ? 2 : 3;
        if (bk && !wr && a[15:0] == 16'h0100) return 4;
        if (bk && !wr && a[15:0] == 16'h0101) return 5;
        return 0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic strobes_any(output logic s);
        s = fifo_clr_o | thr_clr_o | samp_load_o | merged_rd_o | (|thr_load_o) | (|ch_rd_o);
    endtask

    task automatic do_cycle(input logic [23:0] a, input logic [5:0] m, input logic wr,
                            input logic [15:0] d, input logic hold_as, input logic scramble);
        @(negedge clk);
        addr_i = a; am_i = m; write_i = wr; wdata_i = d; as_i = 1'b1; ds_i = 1'b1;
        @(negedge clk);
        g_dt_early = dtack_o;
        if (scramble) begin addr_i = 24'hFFFFFF; am_i = 6'h00; end
        @(negedge clk);
        g_dt = dtack_o; g_rdata = rdata_o; g_tdata = thr_data_o;
        g_fclr = fifo_clr_o; g_tclr = thr_clr_o; g_sload = samp_load_o; g_mrd = merged_rd_o;
        g_thr = thr_load_o; g_chrd = ch_rd_o;
        @(negedge clk);
        g_dt_hold = dtack_o;
        strobes_any(g_pulse2);
        ds_i = 1'b0; as_i = hold_as;
        @(negedge clk);
        g_dt_rel = dtack_o;
    endtask

    task automatic run_check(input int k, input logic [23:0] a, input logic [15:0] d);
        int ch;
        ch = int'(a[15:8]) - 1;
        chk(k == 0 ? "R2 no ack" : "R4 ack edge two", {31'b0, g_dt}, {31'b0, k != 0});
        chk("R4 ack not at edge one", {31'b0, g_dt_early}, 32'd0);
        chk("R4 ack held while ds", {31'b0, g_dt_hold}, {31'b0, k != 0});
        chk("R4 ack release", {31'b0, g_dt_rel}, 32'd0);
        chk("R5 fifo clear pulse", {31'b0, g_fclr}, {31'b0, k == 1 && d[9]});
        chk("R5 threshold clear pulse", {31'b0, g_tclr}, {31'b0, k == 1 && d[10]});
        chk("R5 sample load pulse", {31'b0, g_sload}, {31'b0, k == 1 && d[11]});
        chk("R5 single cycle strobes", {31'b0, g_pulse2}, 32'd0);
        chk("R7 threshold load", g_thr, (k == 2) ? (32'd1 << ch) : 32'd0);
        if (k == 2) chk("R7 threshold word", {16'b0, g_tdata}, {16'b0, d});
        chk("R8 channel read strobe", g_chrd, (k == 3) ? (32'd1 << ch) : 32'd0);
        chk("R9 merged read strobe", {31'b0, g_mrd}, {31'b0, k == 4});
        chk("R12 one read or load strobe", $countones({g_mrd, g_chrd, g_thr}), {31'b0, k >= 2 && k <= 4});
        if (k == 1 && d[11]) m_samp = d[9:0];
        if (k == 1 && d[9]) m_beats = '0;
        if (k == 3) m_rdata = chword(ch);
        if (k == 4) begin m_rdata = merged_data_i; m_beats = m_beats + 1'b1; end
        if (k == 5) m_rdata = m_beats;
        chk("R6 sample count", {22'b0, samp_count_o}, {22'b0, m_samp});
        chk(k == 3 ? "R8 channel data" : k == 4 ? "R9 merged data" : k == 5 ? "R11 beat count" : "R2 read data held",
            {16'b0, g_rdata}, {16'b0, m_rdata});
    endtask

    task automatic access(input logic [23:0] a, input logic [5:0] m, input logic wr, input logic [15:0] d);
        int k;
        k = exp_kind(a, m, wr);
        do_cycle(a, m, wr, d, 1'b0, 1'b0);
        run_check(k, a, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic s;
        for (int k = 0; k < NCH; k++) ch_data_i[k*DW +: DW] = chword(k);
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        strobes_any(s);
        chk("R1 dtack low", {31'b0, dtack_o}, 32'd0);
        chk("R1 strobes low", {31'b0, s}, 32'd0);
        chk("R1 read data zero", {16'b0, rdata_o}, 32'd0);
        chk("R1 sample count default", {22'b0, samp_count_o}, 32'd1020);

        // directed corners
        access({MOD_ID, 16'h0000}, 6'h3D, 1'b1, 16'h0A37);          // R5 R6 load 0x237
        access({8'h06, 16'h0000}, 6'h3D, 1'b1, 16'h0E11);           // R2 stray select
        access({MOD_ID, 16'h0000}, 6'h3B, 1'b1, 16'h0E11);          // R3 wrong modifier
        access({MOD_ID, 16'h0100}, 6'h3D, 1'b1, 16'hBEEF);          // R7 first channel
        access({MOD_ID, 16'h2000}, 6'h3D, 1'b1, 16'h1234);          // R7 last channel
        access({MOD_ID, 16'h2100}, 6'h3D, 1'b1, 16'h1234);          // R7 beyond last
        access({MOD_ID, 16'h0340}, 6'h3D, 1'b0, 16'h0000);          // R7 nonzero low byte
        access({MOD_ID, 16'h2000}, 6'h3D, 1'b0, 16'h0000);          // R8 last channel read
        access({MOD_ID, 16'h0100}, 6'h3D, 1'b0, 16'h0000);          // R8 first channel read
        access({MOD_ID, 16'h0101}, 6'h3F, 1'b0, 16'h0000);          // R11 zero beats

        // R10 three-beat burst with scrambled address after first beat
        for (int b = 0; b < 3; b++) begin
            merged_data_i = 16'hC000 + 16'(b);
            do_cycle({MOD_ID, 16'h0100}, 6'h3B, 1'b0, 16'h0000, b < 2, b > 0);
            run_check(4, {MOD_ID, 16'h0100}, 16'h0000);
            chk("R10 burst beat data", {16'b0, g_rdata}, {16'b0, 16'hC000 + 16'(b)});
        end
        access({MOD_ID, 16'h0101}, 6'h3B, 1'b0, 16'h0000);          // R11 three beats
        chk("R11 count after burst", {16'b0, g_rdata}, 32'd3);
        access({MOD_ID, 16'h0000}, 6'h3D, 1'b1, 16'h0200);          // R5 fifo reset
        access({MOD_ID, 16'h0101}, 6'h3F, 1'b0, 16'h0000);          // R11 cleared
        chk("R11 count after reset", {16'b0, g_rdata}, 32'd0);

        // constrained random
        for (int n = 0; n < 300; n++) begin
            logic [7:0] id;
            logic [15:0] off;
            logic [5:0] m;
            int sel;
            id  = ($urandom % 4 == 0) ? 8'($urandom) : MOD_ID;
            sel = $urandom % 8;
            case (sel)
                0: off = 16'h0000;
                1: off = 16'h0100;
                2: off = 16'h0101;
                3, 4: off = {8'($urandom % 40), 8'h00};
                5: off = {8'($urandom % 40), 8'($urandom)};
                6: off = 16'($urandom);
                default: off = 16'h2000;
            endcase
            case ($urandom % 6)
                0, 1, 2: m = 6'h3D;
                3: m = 6'h3B;
                4: m = 6'h3F;
                default: m = 6'($urandom);
            endcase
            merged_data_i = 16'($urandom);
            access({id, off}, m, 1'($urandom), 16'($urandom));
        end
        finish_run();
    end

endmodule